// File: doc/BRIEF.md
# Vector Descriptor Cursor Unit

This block keeps one descriptor per logical vector register. A descriptor places the vector on a contiguous run of element slots inside the data cache. Each slot holds one 128-bit element, which is the width of one sub-word SIMD operand. The descriptor records where the run begins, how many elements it holds, a cursor pointing at the element now in use, and how many elements memory has delivered so far. When a SIMD instruction names a vector register as an operand, the block looks up the descriptor and adds the cursor to the base. This produces the physical slot index within the same cycle. The cursor then walks forward when increment commands arrive.

A read of an element that has not yet arrived raises a stall instead of a valid indication, so a consumer can run ahead of the fetch without reading stale data. A single increment command can advance up to three vectors together: two sources and one destination. When a vector's cursor is on its last element and is advanced again, the cursor stops and an end-of-vector flag is raised. The cache arrays, the memory fetch engine and the allocation policy sit outside this block. The block only sees configure writes and arrival pulses.

Each descriptor runs a small state machine. The states are D_FREE (unconfigured), D_WALK (configured, cursor may advance) and D_DONE (cursor exhausted). The transitions are:

- cfg_open: D_FREE to D_WALK, on a configure write with non-zero length.
- cfg_reopen: D_WALK or D_DONE to D_WALK, on a configure write with non-zero length.
- cfg_release: any state to D_FREE, on a configure write with zero length.
- step_last: D_WALK to D_DONE, on an increment while the cursor is on the last element.
- hold: stay in the current state in every other case.

Top module: `vec_desc_unit`

## Requirements
- R1: After reset every vector is in D_FREE, eov is all zero, and a read of any vector stalls. A configure write with non-zero length stores the start and length, sets the cursor and arrival count to zero, and clears that vector's eov bit from the next cycle on.
- R2: In the cycle rd_valid is high, rd_slot equals start plus cursor of vector rd_vid. rd_ok is high in that same cycle when the vector is in D_WALK and its cursor is below its arrival count.
- R3: An increment command advances by one the cursor of each vector named by an enabled field (inc_a, inc_b, inc_d), up to three distinct vectors in one cycle.
- R4: A read whose cursor is not below the arrival count, or that targets a vector not in D_WALK, drives rd_stall high and rd_ok low. rd_ok and rd_stall are never high together, and both are low when rd_valid is low.
- R5: A vector named in more than one field of the same increment command advances by exactly one.
- R6: An increment while the cursor equals length minus one leaves the cursor unchanged, moves the vector to D_DONE and sets its eov bit. Reads then stall, further increments change nothing, and eov stays set until the vector is configured again.
- R7: Each fill pulse for a configured vector raises its arrival count by one, up to the length, so element k becomes readable only after k+1 fills.
- R8: The slot index wraps modulo 2^SLOT_W. For example, start 62 with cursor 2 gives slot 0 when SLOT_W is 6.
- R9: A configure write with length zero returns the vector to D_FREE. Reads then stall, and increments and fills to it have no effect.
- R10: A configure write to a vector takes priority over a fill or increment naming the same vector in the same cycle. That vector starts with cursor 0 and arrival count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configure-write strobe |
| cfg_vid | input | 3 | Vector being configured |
| cfg_start | input | SLOT_W | First slot of the vector |
| cfg_len | input | SLOT_W+1 | Element count; zero releases the vector |
| fill_en | input | 1 | One element of fill_vid has arrived |
| fill_vid | input | 3 | Vector receiving the element |
| inc_a_en | input | 1 | First source field of the increment is valid |
| inc_a_vid | input | 3 | First source vector |
| inc_b_en | input | 1 | Second source field is valid |
| inc_b_vid | input | 3 | Second source vector |
| inc_d_en | input | 1 | Destination field is valid |
| inc_d_vid | input | 3 | Destination vector |
| rd_valid | input | 1 | Operand lookup request |
| rd_vid | input | 3 | Vector named by the operand |
| rd_slot | output | SLOT_W | Physical slot index, same cycle |
| rd_ok | output | 1 | Element present; the slot may be used |
| rd_stall | output | 1 | Element not yet available or vector inactive |
| eov | output | NUM_VEC | Per-vector end-of-vector flags |

## Verification
On every cycle, the assertions check the following. rd_ok and rd_stall never collide. Both are quiet without a request. An eov bit cannot drop without a configure write. A freshly configured vector stalls. A looked-up slot holds still when nothing touches its vector, and it steps by exactly one after an increment. Other behaviour depends on a particular sequence of commands, so only the bench's scenarios can show it. This covers the cursor saturating and raising eov at the last element, duplicate names in one increment advancing once, the wrap of the slot index, configure-over-increment priority, and a release making later fills and increments inert.

// File: rtl/vdu_pkg.sv
package vdu_pkg;

    typedef enum logic [1:0] {
        D_FREE = 2'd0,
        D_WALK = 2'd1,
        D_DONE = 2'd2
    } dstate_e;

endpackage

// File: rtl/vdu_cmd_decode.sv
module vdu_cmd_decode #(
    parameter int NUM_VEC = 8,
    localparam int VID_W = $clog2(NUM_VEC)
) (
    input  logic               a_en,
    input  logic [VID_W-1:0]   a_vid,
    input  logic               b_en,
    input  logic [VID_W-1:0]   b_vid,
    input  logic               d_en,
    input  logic [VID_W-1:0]   d_vid,
    output logic [NUM_VEC-1:0] hit
);

    // A vector named twice or three times still yields a single hit bit.
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_hit
        assign hit[i] = (a_en && (a_vid == VID_W'(i)))
                     || (b_en && (b_vid == VID_W'(i)))
                     || (d_en && (d_vid == VID_W'(i)));
    end

endmodule

// File: rtl/vdu_entry.sv
module vdu_entry
    import vdu_pkg::*;
#(
    parameter int SLOT_W = 6,
    localparam int CNT_W = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_hit,
    input  logic [SLOT_W-1:0] cfg_start,
    input  logic [CNT_W-1:0]  cfg_len,
    input  logic              fill_hit,
    input  logic              inc_hit,
    output logic [SLOT_W-1:0] q_start,
    output logic [CNT_W-1:0]  q_cur,
    output logic [CNT_W-1:0]  q_avail,
    output logic              q_walk,
    output logic              q_done
);

    dstate_e          state;
    dstate_e          nxt;
    logic [CNT_W-1:0] q_len;
    logic             at_last;
    logic             len_zero;

    assign at_last  = ((q_cur + 1'b1) == q_len);
    assign len_zero = (cfg_len == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= D_FREE;
        else        state <= nxt;
    end

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            D_FREE: begin
                if (cfg_hit && !len_zero) nxt = D_WALK;            // cfg_open
            end
            D_WALK: begin
                if (cfg_hit)                   nxt = len_zero ? D_FREE : D_WALK;
                else if (inc_hit && at_last)   nxt = D_DONE;        // step_last
            end
            D_DONE: begin
                if (cfg_hit)                   nxt = len_zero ? D_FREE : D_WALK;
            end
            default: nxt = D_FREE;
        endcase
    end

    // descriptor fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_start <= '0;
            q_len   <= '0;
            q_cur   <= '0;
            q_avail <= '0;
        end else if (cfg_hit) begin
            q_start <= cfg_start;
            q_len   <= cfg_len;
            q_cur   <= '0;
            q_avail <= '0;
        end else begin
            if (fill_hit && (state != D_FREE) && (q_avail < q_len))
                q_avail <= q_avail + 1'b1;
            if (inc_hit && (state == D_WALK) && !at_last)
                q_cur <= q_cur + 1'b1;
        end
    end

    // outputs from state
    always_comb begin
        q_walk = 1'b0;
        q_done = 1'b0;
        unique case (state)
            D_FREE:  ;
            D_WALK:  q_walk = 1'b1;
            D_DONE:  q_done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/vdu_index.sv
module vdu_index #(
    parameter int NUM_VEC = 8,
    parameter int SLOT_W  = 6,
    localparam int VID_W  = $clog2(NUM_VEC),
    localparam int CNT_W  = SLOT_W + 1
) (
    input  logic                            rd_valid,
    input  logic [VID_W-1:0]                rd_vid,
    input  logic [NUM_VEC-1:0][SLOT_W-1:0]  v_start,
    input  logic [NUM_VEC-1:0][CNT_W-1:0]   v_cur,
    input  logic [NUM_VEC-1:0][CNT_W-1:0]   v_avail,
    input  logic [NUM_VEC-1:0]              v_walk,
    output logic [SLOT_W-1:0]               rd_slot,
    output logic                            rd_ok,
    output logic                            rd_stall
);

    logic [CNT_W-1:0] sel_cur;
    logic [CNT_W-1:0] sel_avail;
    logic             present;

    // one lookup, one add: nothing else in the path
    assign sel_cur   = v_cur[rd_vid];
    assign sel_avail = v_avail[rd_vid];
    assign rd_slot   = v_start[rd_vid] + sel_cur[SLOT_W-1:0];
    assign present   = v_walk[rd_vid] && (sel_cur < sel_avail);
    assign rd_ok     = rd_valid && present;
    assign rd_stall  = rd_valid && !present;

endmodule

// File: rtl/vec_desc_unit.sv
module vec_desc_unit #(
    parameter int NUM_VEC = 8,
    parameter int SLOT_W  = 6,
    localparam int VID_W  = $clog2(NUM_VEC),
    localparam int CNT_W  = SLOT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [VID_W-1:0]   cfg_vid,
    input  logic [SLOT_W-1:0]  cfg_start,
    input  logic [CNT_W-1:0]   cfg_len,
    input  logic               fill_en,
    input  logic [VID_W-1:0]   fill_vid,
    input  logic               inc_a_en,
    input  logic [VID_W-1:0]   inc_a_vid,
    input  logic               inc_b_en,
    input  logic [VID_W-1:0]   inc_b_vid,
    input  logic               inc_d_en,
    input  logic [VID_W-1:0]   inc_d_vid,
    input  logic               rd_valid,
    input  logic [VID_W-1:0]   rd_vid,
    output logic [SLOT_W-1:0]  rd_slot,
    output logic               rd_ok,
    output logic               rd_stall,
    output logic [NUM_VEC-1:0] eov
);

    logic [NUM_VEC-1:0]             inc_hit;
    logic [NUM_VEC-1:0][SLOT_W-1:0] v_start;
    logic [NUM_VEC-1:0][CNT_W-1:0]  v_cur;
    logic [NUM_VEC-1:0][CNT_W-1:0]  v_avail;
    logic [NUM_VEC-1:0]             v_walk;

    vdu_cmd_decode #(.NUM_VEC(NUM_VEC)) u_dec (
        .a_en  (inc_a_en),
        .a_vid (inc_a_vid),
        .b_en  (inc_b_en),
        .b_vid (inc_b_vid),
        .d_en  (inc_d_en),
        .d_vid (inc_d_vid),
        .hit   (inc_hit)
    );

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_desc
        vdu_entry #(.SLOT_W(SLOT_W)) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_hit   (cfg_we && (cfg_vid == VID_W'(i))),
            .cfg_start (cfg_start),
            .cfg_len   (cfg_len),
            .fill_hit  (fill_en && (fill_vid == VID_W'(i))),
            .inc_hit   (inc_hit[i]),
            .q_start   (v_start[i]),
            .q_cur     (v_cur[i]),
            .q_avail   (v_avail[i]),
            .q_walk    (v_walk[i]),
            .q_done    (eov[i])
        );
    end

    vdu_index #(.NUM_VEC(NUM_VEC), .SLOT_W(SLOT_W)) u_idx (
        .rd_valid (rd_valid),
        .rd_vid   (rd_vid),
        .v_start  (v_start),
        .v_cur    (v_cur),
        .v_avail  (v_avail),
        .v_walk   (v_walk),
        .rd_slot  (rd_slot),
        .rd_ok    (rd_ok),
        .rd_stall (rd_stall)
    );

endmodule

// File: rtl/vec_desc_unit_chk.sv
module vec_desc_unit_chk #(
    parameter int NUM_VEC = 8,
    parameter int SLOT_W  = 6,
    localparam int VID_W  = $clog2(NUM_VEC),
    localparam int CNT_W  = SLOT_W + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_we,
    input logic [VID_W-1:0]   cfg_vid,
    input logic [CNT_W-1:0]   cfg_len,
    input logic               fill_en,
    input logic               inc_a_en,
    input logic [VID_W-1:0]   inc_a_vid,
    input logic               inc_b_en,
    input logic [VID_W-1:0]   inc_b_vid,
    input logic               inc_d_en,
    input logic [VID_W-1:0]   inc_d_vid,
    input logic               rd_valid,
    input logic [VID_W-1:0]   rd_vid,
    input logic [SLOT_W-1:0]  rd_slot,
    input logic               rd_ok,
    input logic               rd_stall,
    input logic [NUM_VEC-1:0] eov
);

    logic cfg_touch;
    logic inc_touch;
    assign cfg_touch = cfg_we && (cfg_vid == rd_vid);
    assign inc_touch = (inc_a_en && (inc_a_vid == rd_vid))
                    || (inc_b_en && (inc_b_vid == rd_vid))
                    || (inc_d_en && (inc_d_vid == rd_vid));

    a_r1_reset_eov: assert property (@(posedge clk)
        !rst_n |=> (eov == '0));

    a_r1_cfg_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_len != '0) |=>
            (!(rd_valid && rd_vid == $past(cfg_vid)) || rd_stall));

    a_r4_ok_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_ok != rd_stall));

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (!rd_ok && !rd_stall));

    a_r2_slot_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !cfg_touch && !inc_touch) |=>
            (!(rd_valid && rd_vid == $past(rd_vid)) || rd_slot == $past(rd_slot)));

    a_r3_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && inc_touch && !cfg_touch) |=>
            (!(rd_valid && rd_vid == $past(rd_vid) && !eov[rd_vid])
             || rd_slot == SLOT_W'($past(rd_slot) + 1'b1)));

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_eov
        a_r6_eov_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (eov[i] && !(cfg_we && cfg_vid == VID_W'(i))) |=> eov[i]);
    end

    // fill_en is part of the watched interface; keep it referenced
    logic unused_fill;
    assign unused_fill = fill_en;

endmodule

bind vec_desc_unit vec_desc_unit_chk #(.NUM_VEC(NUM_VEC), .SLOT_W(SLOT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_vid   (cfg_vid),
    .cfg_len   (cfg_len),
    .fill_en   (fill_en),
    .inc_a_en  (inc_a_en),
    .inc_a_vid (inc_a_vid),
    .inc_b_en  (inc_b_en),
    .inc_b_vid (inc_b_vid),
    .inc_d_en  (inc_d_en),
    .inc_d_vid (inc_d_vid),
    .rd_valid  (rd_valid),
    .rd_vid    (rd_vid),
    .rd_slot   (rd_slot),
    .rd_ok     (rd_ok),
    .rd_stall  (rd_stall),
    .eov       (eov)
);

// File: tb/sim_vec_desc_unit.sv
`timescale 1ns/1ps
module sim_vec_desc_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_vid = '0;
    logic [5:0] cfg_start = '0;
    logic [6:0] cfg_len = '0;
    logic       fill_en = 1'b0;
    logic [2:0] fill_vid = '0;
    logic       inc_a_en = 1'b0, inc_b_en = 1'b0, inc_d_en = 1'b0;
    logic [2:0] inc_a_vid = '0, inc_b_vid = '0, inc_d_vid = '0;
    logic       rd_valid = 1'b0;
    logic [2:0] rd_vid = '0;
    logic [5:0] rd_slot;
    logic       rd_ok, rd_stall;
    logic [7:0] eov;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vec_desc_unit u0 (.*);

    typedef struct packed {
        logic cw; logic [2:0] cv; logic [5:0] cs; logic [6:0] cl;
        logic fe; logic [2:0] fv;
        logic ae; logic [2:0] av;
        logic be; logic [2:0] bv;
        logic de; logic [2:0] dv;
        logic re; logic [2:0] rv;
        logic xok; logic [5:0] xslot; logic [7:0] xeov;
        logic [3:0] req;
    } row_t;

    localparam int NROW = 26;
    // cw cv cs cl | fe fv | ae av | be bv | de dv | re rv | xok xslot xeov | req
    localparam row_t TBL [NROW] = '{
        '{0,0, 0,0, 0,0, 0,0, 0,0, 0,0, 1,0, 0, 0,8'h00, 1},  // R1 unconfigured stalls
        '{1,0, 8,3, 0,0, 0,0, 0,0, 0,0, 1,0, 0, 0,8'h00, 1},  // R1 cfg v0
        '{1,1,20,2, 0,0, 0,0, 0,0, 0,0, 1,0, 0, 0,8'h00, 4},  // R4 nothing arrived
        '{0,0, 0,0, 1,0, 0,0, 0,0, 0,0, 1,0, 0, 0,8'h00, 4},  // R4
        '{0,0, 0,0, 1,1, 0,0, 0,0, 0,0, 1,0, 1, 8,8'h00, 2},  // R2 slot 8
        '{0,0, 0,0, 0,0, 1,0, 1,1, 0,0, 1,1, 1,20,8'h00, 3},  // R3 two vectors advance
        '{0,0, 0,0, 0,0, 0,0, 0,0, 0,0, 1,0, 0, 0,8'h00, 4},  // R4 cursor caught up
        '{0,0, 0,0, 1,0, 0,0, 0,0, 0,0, 1,1, 0, 0,8'h00, 4},  // R4
        '{0,0, 0,0, 1,0, 0,0, 0,0, 0,0, 1,0, 1, 9,8'h00, 7},  // R7 second fill
        '{0,0, 0,0, 1,0, 1,0, 1,0, 1,0, 1,0, 1, 9,8'h00, 5},  // R5 triple name
        '{0,0, 0,0, 0,0, 0,0, 0,0, 1,0, 1,0, 1,10,8'h00, 5},  // R5 moved once
        '{0,0, 0,0, 0,0, 0,0, 0,0, 0,0, 1,0, 0, 0,8'h01, 6},  // R6 end reached
        '{0,0, 0,0, 0,0, 1,0, 0,0, 0,0, 1,0, 0, 0,8'h01, 6},  // R6
        '{1,0,62,4, 0,0, 0,0, 0,0, 0,0, 1,0, 0, 0,8'h01, 6},  // R6 eov holds
        '{0,0, 0,0, 1,0, 0,0, 0,0, 0,0, 1,0, 0, 0,8'h00, 1},  // R1 eov cleared
        '{0,0, 0,0, 0,0, 1,0, 0,0, 0,0, 1,0, 1,62,8'h00, 2},  // R2
        '{0,0, 0,0, 1,0, 0,0, 0,0, 0,0, 1,0, 0, 0,8'h00, 4},  // R4
        '{0,0, 0,0, 0,0, 0,0, 1,0, 0,0, 1,0, 1,63,8'h00, 3},  // R3
        '{0,0, 0,0, 1,0, 0,0, 0,0, 0,0, 1,0, 0, 0,8'h00, 4},  // R4
        '{0,0, 0,0, 0,0, 0,0, 0,0, 0,0, 1,0, 1, 0,8'h00, 8},  // R8 wrap
        '{1,0, 0,0, 0,0, 0,0, 0,0, 0,0, 1,0, 1, 0,8'h00, 8},  // R8 release issued
        '{0,0, 0,0, 1,0, 1,0, 0,0, 0,0, 1,0, 0, 0,8'h00, 9},  // R9 released
        '{1,0, 5,2, 1,0, 1,0, 0,0, 0,0, 1,0, 0, 0,8'h00, 9},  // R9 / R10 collide
        '{0,0, 0,0, 0,0, 0,0, 0,0, 0,0, 1,0, 0, 0,8'h00,10},  // R10 fill dropped
        '{0,0, 0,0, 1,0, 0,0, 0,0, 0,0, 1,0, 0, 0,8'h00,10},  // R10
        '{0,0, 0,0, 0,0, 0,0, 0,0, 0,0, 1,0, 1, 5,8'h00,10}   // R10 inc dropped
    };

    task automatic chk(input string rq, input logic xok, input logic [5:0] xslot,
                       input logic [7:0] xeov, input logic req_on);
        n_chk++;
        if (rd_ok !== xok || rd_stall !== (req_on && !xok) ||
            (xok && rd_slot !== xslot) || eov !== xeov) begin
            n_bad++;
            $display("FAIL %s: ok=%0b stall=%0b slot=%0d eov=%h expected ok=%0b stall=%0b slot=%0d eov=%h",
                     rq, rd_ok, rd_stall, rd_slot, eov, xok, req_on && !xok, xslot, xeov);
        end
    endtask

    task automatic idle();
        cfg_we = 0; fill_en = 0; inc_a_en = 0; inc_b_en = 0; inc_d_en = 0; rd_valid = 0;
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < NROW; i++) begin
            @(negedge clk);
            cfg_we = TBL[i].cw; cfg_vid = TBL[i].cv; cfg_start = TBL[i].cs; cfg_len = TBL[i].cl;
            fill_en = TBL[i].fe; fill_vid = TBL[i].fv;
            inc_a_en = TBL[i].ae; inc_a_vid = TBL[i].av;
            inc_b_en = TBL[i].be; inc_b_vid = TBL[i].bv;
            inc_d_en = TBL[i].de; inc_d_vid = TBL[i].dv;
            rd_valid = TBL[i].re; rd_vid = TBL[i].rv;
            #1;
            chk($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].xok, TBL[i].xslot,
                TBL[i].xeov, TBL[i].re);
        end
        @(negedge clk); idle();

        // R4: no request, no response
        #1; chk("R4 idle", 1'b0, 6'd0, 8'h00, 1'b0);

        // R3: three distinct vectors advance in one command
        for (int v = 2; v <= 4; v++) begin
            @(negedge clk); idle();
            cfg_we = 1; cfg_vid = 3'(v); cfg_len = 7'd4;
            cfg_start = (v == 2) ? 6'd0 : (v == 3) ? 6'd10 : 6'd40;
        end
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); idle();
            fill_en = 1; fill_vid = 3'(2 + k % 3);
        end
        @(negedge clk); idle();
        inc_a_en = 1; inc_a_vid = 3'd2;
        inc_b_en = 1; inc_b_vid = 3'd3;
        inc_d_en = 1; inc_d_vid = 3'd4;
        for (int v = 2; v <= 4; v++) begin
            @(negedge clk); idle();
            rd_valid = 1; rd_vid = 3'(v);
            #1;
            chk("R3 three-way", 1'b1, (v == 2) ? 6'd1 : (v == 3) ? 6'd11 : 6'd41, 8'h00, 1'b1);
        end

        // R1: reset mid-run returns every vector to unconfigured
        @(negedge clk); idle(); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int v = 0; v < 8; v++) begin
            @(negedge clk); idle();
            rd_valid = 1; rd_vid = 3'(v);
            #1;
            chk("R1 after reset", 1'b0, 6'd0, 8'h00, 1'b1);
        end
        @(negedge clk); idle();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule